// File: doc/BRIEF.md
# Tap Position Register Bank Controller

This block holds the position state of four tap-selecting channels. Each channel owns a volatile 6-bit position register and four 6-bit data registers that stand in for nonvolatile storage. A serial front end decodes host traffic into single-cycle commands, and this block executes them. The commands cover the following:

- loading or reading a position register;
- loading or reading a data register;
- copying between a data register and the position register in either direction;
- a global copy that loads every channel's position register from the data register selected by `cmd_reg_i`;
- a single-step increment or decrement of the position register.

Each channel drives a 64-bit one-hot tap select decoded from its position. When reset is released, each position register recalls its channel's data register 0. Any command that changes a data register starts a nonvolatile write period. The length of that period is set by the parameter `NV_CYCLES`, and its default is 10 ms at 50 MHz. During the period `busy_o` is high and further data register changes are refused. A low level on the write-protect input blocks every data register change but leaves position changes alone.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: While `rst_ni` is low, every position register reads 0. On the first clock edge after release, each position register loads its channel's data register 0. Data register 0 of channel c resets to field c of `DR_INIT` (defaults 10, 20, 30, 40 for channels 0 to 3), and the other data registers reset to 0. Commands presented in that first cycle are ignored.
- R2: Opcode 1 loads `cmd_data_i` into the position register of channel `cmd_ch_i`. Other channels keep their positions.
- R3: Opcode 5 copies data register `cmd_reg_i` of channel `cmd_ch_i` into that channel's position register.
- R4: Opcode 7 loads every channel's position register from its own data register `cmd_reg_i` in one cycle. This copy ignores `cmd_ch_i`.
- R5: Opcode 8 increments the addressed position by one and opcode 9 decrements it by one. Increment holds at 63 and decrement holds at 0.
- R6: Channel c's tap select occupies `tap_sel_o[c*64 +: 64]`. It has exactly one bit set, at the index equal to that channel's position.
- R7: Opcode 3 writes `cmd_data_i` into data register `cmd_reg_i`. Opcode 6 copies the position register into data register `cmd_reg_i`. Either command, when accepted, raises `busy_o` from the next cycle for exactly `NV_CYCLES` cycles.
- R8: While `wp_ni` is low, opcodes 3 and 6 change no data register and do not raise `busy_o`. Position register commands still take effect.
- R9: While `busy_o` is high, opcodes 3 and 6 are ignored.
- R10: Opcode 2 reads the position register and opcode 4 reads data register `cmd_reg_i`. In the cycle after the command, `rd_valid_o` is high and `rd_data_o` holds the register's value from before that edge. `rd_valid_o` is low in every other cycle.
- R11: Opcode 0 and the opcodes 10 to 15 change no register, do not raise `busy_o` and return no read. With `cmd_valid_i` low, positions stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 4 | Opcode |
| cmd_ch_i | input | 2 | Channel index |
| cmd_reg_i | input | 2 | Data register index |
| cmd_data_i | input | 6 | Write data |
| wp_ni | input | 1 | Write protect, active low |
| busy_o | output | 1 | Nonvolatile write in progress |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 6 | Read data |
| pos_o | output | 24 | Position registers, channel c at bits c*6 +: 6 |
| tap_sel_o | output | 256 | One-hot tap selects, channel c at bits c*64 +: 64 |

## Verification
The position register is exercised through all four of its load paths:

- direct write;
- single-channel copy;
- global copy;
- stepping, run at the saturation points 63 and 0 as well as mid-range.

After each load, all four channels are compared, so a load that reaches the wrong channel or misses one shows up. Data register changes are attempted in three situations: open, under write protect, and during the busy period. Each attempt is followed by a readback, which separates a blocked write from a lost one. The length of the busy window is counted edge to edge. An undefined opcode is sent to confirm that it leaves no trace.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_WR_POS   = 4'd1,
    OP_RD_POS   = 4'd2,
    OP_WR_DR    = 4'd3,
    OP_RD_DR    = 4'd4,
    OP_DR2POS   = 4'd5,
    OP_POS2DR   = 4'd6,
    OP_G_DR2POS = 4'd7,
    OP_INC      = 4'd8,
    OP_DEC      = 4'd9
  } wbc_op_e;
endpackage

// File: rtl/wbc_nv_timer.sv
module wbc_nv_timer #(
  parameter int unsigned NV_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(NV_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CNT_W'(NV_CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/wbc_tap_decode.sv
module wbc_tap_decode #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0]        pos_i,
  output logic [(1<<W)-1:0]   sel_o
);
  always_comb begin
    sel_o        = '0;
    sel_o[pos_i] = 1'b1;
  end
endmodule

// File: rtl/wbc_channel.sv
module wbc_channel
  import wbc_pkg::*;
#(
  parameter int unsigned W      = 6,
  parameter int unsigned NDR    = 4,
  parameter logic [W-1:0] DR_RST = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  recall_i,
  input  logic                  sel_i,
  input  wbc_op_e               op_i,
  input  logic [$clog2(NDR)-1:0] reg_i,
  input  logic [W-1:0]          data_i,
  input  logic                  dr_wr_ok_i,
  output logic [W-1:0]          pos_o,
  output logic [NDR*W-1:0]      dr_o
);
  localparam logic [W-1:0] POS_MAX = '1;

  logic [W-1:0] pos_q;
  logic [W-1:0] dr_q [NDR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (recall_i) begin
      pos_q <= dr_q[0];
    end else if (op_i == OP_G_DR2POS) begin
      pos_q <= dr_q[reg_i];
    end else if (sel_i) begin
      case (op_i)
        OP_WR_POS: pos_q <= data_i;
        OP_DR2POS: pos_q <= dr_q[reg_i];
        OP_INC:    if (pos_q != POS_MAX) pos_q <= pos_q + W'(1);
        OP_DEC:    if (pos_q != '0)      pos_q <= pos_q - W'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NDR; r++) dr_q[r] <= (r == 0) ? DR_RST : '0;
    end else if (sel_i && dr_wr_ok_i && !recall_i) begin
      if (op_i == OP_WR_DR)       dr_q[reg_i] <= data_i;
      else if (op_i == OP_POS2DR) dr_q[reg_i] <= pos_q;
    end
  end

  assign pos_o = pos_q;
  for (genvar r = 0; r < NDR; r++) begin : g_dr_out
    assign dr_o[r*W +: W] = dr_q[r];
  end
endmodule

// File: rtl/wiper_bank_ctrl.sv
module wiper_bank_ctrl
  import wbc_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned NDR       = 4,
  parameter int unsigned W         = 6,
  parameter int unsigned NV_CYCLES = 500000,
  parameter logic [NCH*W-1:0] DR_INIT = {6'd40, 6'd30, 6'd20, 6'd10}
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_valid_i,
  input  logic [3:0]                  cmd_op_i,
  input  logic [$clog2(NCH)-1:0]      cmd_ch_i,
  input  logic [$clog2(NDR)-1:0]      cmd_reg_i,
  input  logic [W-1:0]                cmd_data_i,
  input  logic                        wp_ni,
  output logic                        busy_o,
  output logic                        rd_valid_o,
  output logic [W-1:0]                rd_data_o,
  output logic [NCH*W-1:0]            pos_o,
  output logic [NCH*(1<<W)-1:0]       tap_sel_o
);
  localparam int unsigned TAPS = 1 << W;

  logic         recall_q;
  wbc_op_e      op;
  logic         dr_op;
  logic         dr_wr_ok;
  logic         nv_start;
  logic [W-1:0] pos_a [NCH];
  logic [W-1:0] dr_a  [NCH][NDR];
  logic         rd_valid_q;
  logic [W-1:0] rd_data_q;

  // first cycle after reset is the recall cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) recall_q <= 1'b1;
    else         recall_q <= 1'b0;
  end

  assign op       = (cmd_valid_i && !recall_q) ? wbc_op_e'(cmd_op_i) : OP_NOP;
  assign dr_op    = (op == OP_WR_DR) || (op == OP_POS2DR);
  assign dr_wr_ok = wp_ni && !busy_o;
  assign nv_start = dr_op && dr_wr_ok;

  wbc_nv_timer #(.NV_CYCLES(NV_CYCLES)) i_nv_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(nv_start),
    .busy_o (busy_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NDR*W-1:0] dr_flat;

    wbc_channel #(
      .W     (W),
      .NDR   (NDR),
      .DR_RST(DR_INIT[c*W +: W])
    ) i_channel (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .recall_i  (recall_q),
      .sel_i     (cmd_ch_i == ($clog2(NCH))'(c)),
      .op_i      (op),
      .reg_i     (cmd_reg_i),
      .data_i    (cmd_data_i),
      .dr_wr_ok_i(dr_wr_ok),
      .pos_o     (pos_a[c]),
      .dr_o      (dr_flat)
    );

    for (genvar r = 0; r < NDR; r++) begin : g_dr
      assign dr_a[c][r] = dr_flat[r*W +: W];
    end

    wbc_tap_decode #(.W(W)) i_tap_decode (
      .pos_i(pos_a[c]),
      .sel_o(tap_sel_o[c*TAPS +: TAPS])
    );

    assign pos_o[c*W +: W] = pos_a[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= (op == OP_RD_POS) || (op == OP_RD_DR);
      if (op == OP_RD_POS)     rd_data_q <= pos_a[cmd_ch_i];
      else if (op == OP_RD_DR) rd_data_q <= dr_a[cmd_ch_i][cmd_reg_i];
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker
  import wbc_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned W   = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   recall_q,
  input logic                   cmd_valid_i,
  input logic [3:0]             cmd_op_i,
  input logic [$clog2(NCH)-1:0] cmd_ch_i,
  input logic                   wp_ni,
  input logic                   busy_o,
  input logic                   rd_valid_o,
  input logic [NCH*W-1:0]       pos_o,
  input logic [NCH*(1<<W)-1:0]  tap_sel_o
);
  localparam int unsigned TAPS = 1 << W;
  localparam int unsigned CW   = $clog2(NCH);
  localparam logic [W-1:0] PMAX = '1;

  logic live, is_dr_op, is_rd_op;
  assign live     = cmd_valid_i && !recall_q;
  assign is_dr_op = (cmd_op_i == OP_WR_DR) || (cmd_op_i == OP_POS2DR);
  assign is_rd_op = (cmd_op_i == OP_RD_POS) || (cmd_op_i == OP_RD_DR);

  AST_NV_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && is_dr_op && wp_ni && !busy_o |=> busy_o); // R7

  AST_WP_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && is_dr_op && !wp_ni && !busy_o |=> !busy_o); // R8

  AST_RD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && is_rd_op |=> rd_valid_o); // R10

  AST_RD_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(live && is_rd_op) |=> !rd_valid_o); // R10

  AST_IDLE_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i && !recall_q |=> $stable(pos_o)); // R11

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_TAP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(tap_sel_o[c*TAPS +: TAPS]) == 1); // R6

    AST_TAP_AT_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tap_sel_o[c*TAPS + int'(pos_o[c*W +: W])]); // R6

    AST_INC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live && cmd_op_i == OP_INC && cmd_ch_i == CW'(c) |=>
      pos_o[c*W +: W] == (($past(pos_o[c*W +: W]) == PMAX) ? PMAX
                          : $past(pos_o[c*W +: W]) + W'(1))); // R5

    AST_DEC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live && cmd_op_i == OP_DEC && cmd_ch_i == CW'(c) |=>
      pos_o[c*W +: W] == (($past(pos_o[c*W +: W]) == '0) ? '0
                          : $past(pos_o[c*W +: W]) - W'(1))); // R5
  end
endmodule

bind wiper_bank_ctrl wbc_checker #(.NCH(NCH), .W(W)) i_wbc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .recall_q   (recall_q),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .cmd_ch_i   (cmd_ch_i),
  .wp_ni      (wp_ni),
  .busy_o     (busy_o),
  .rd_valid_o (rd_valid_o),
  .pos_o      (pos_o),
  .tap_sel_o  (tap_sel_o)
);

// File: tb/test_wiper_bank_ctrl.sv
`timescale 1ns/1ps
module test_wiper_bank_ctrl;
  localparam int NV = 20;
  localparam logic [23:0] INIT = {6'd40, 6'd30, 6'd20, 6'd10};

  logic clk = 1'b0, rst_n = 1'b0;
  logic v = 1'b0, wp = 1'b1;
  logic [3:0] op = '0;
  logic [1:0] ch = '0, rg = '0;
  logic [5:0] d = '0;
  logic busy, rdv;
  logic [5:0] rdd;
  logic [23:0] pos;
  logic [255:0] tap;

  int checks = 0, fails = 0;
  logic [5:0] m_pos [4];
  logic [5:0] m_dr  [4][4];
  int m_cnt;
  logic m_recall;
  logic [5:0] q [$];

  always #10 clk = ~clk;

  wiper_bank_ctrl #(.NV_CYCLES(NV), .DR_INIT(INIT)) i_wiper_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(v), .cmd_op_i(op), .cmd_ch_i(ch),
    .cmd_reg_i(rg), .cmd_data_i(d), .wp_ni(wp), .busy_o(busy), .rd_valid_o(rdv),
    .rd_data_o(rdd), .pos_o(pos), .tap_sel_o(tap));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model, fed from the same inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_pos[c] = 0;
        for (int r = 0; r < 4; r++) m_dr[c][r] = (r == 0) ? INIT[c*6 +: 6] : 6'd0;
      end
      m_cnt = 0; m_recall = 1'b1;
    end else if (m_recall) begin
      for (int c = 0; c < 4; c++) m_pos[c] = m_dr[c][0];
      m_recall = 1'b0;
    end else begin
      bit acc;
      acc = v && (op == 4'd3 || op == 4'd6) && wp && (m_cnt == 0);
      if (v) case (op)
        4'd1: m_pos[ch] = d;
        4'd2: q.push_back(m_pos[ch]);
        4'd3: if (acc) m_dr[ch][rg] = d;
        4'd4: q.push_back(m_dr[ch][rg]);
        4'd5: m_pos[ch] = m_dr[ch][rg];
        4'd6: if (acc) m_dr[ch][rg] = m_pos[ch];
        4'd7: for (int c = 0; c < 4; c++) m_pos[c] = m_dr[c][rg];
        4'd8: if (m_pos[ch] != 63) m_pos[ch] = m_pos[ch] + 1;
        4'd9: if (m_pos[ch] != 0)  m_pos[ch] = m_pos[ch] - 1;
        default: ;
      endcase
      if (acc) m_cnt = NV; else if (m_cnt > 0) m_cnt--;
    end
  end

  // monitor: pops expected read data
  always @(negedge clk) begin
    if (rst_n && rdv) begin
      if (q.size() == 0) chk(1'b0, "R10/R11 unexpected read", int'(rdd), -1);
      else begin
        logic [5:0] e;
        e = q.pop_front();
        chk(rdd == e, "R10 read data", int'(rdd), int'(e));
      end
    end
  end

  task automatic issue(input logic [3:0] o, input logic [1:0] c, input logic [1:0] r,
                       input logic [5:0] dd);
    @(negedge clk); v = 1'b1; op = o; ch = c; rg = r; d = dd;
    @(negedge clk); v = 1'b0;
  endtask

  task automatic check_state(input string req);
    for (int c = 0; c < 4; c++) begin
      chk(pos[c*6 +: 6] == m_pos[c], req, int'(pos[c*6 +: 6]), int'(m_pos[c]));
      chk(tap[c*64 +: 64] == (64'd1 << m_pos[c]), "R6 tap one-hot",
          int'($countones(tap[c*64 +: 64])), 1);
    end
    chk(busy == (m_cnt != 0), {req, " busy"}, int'(busy), int'(m_cnt != 0));
  endtask

  task automatic wait_idle();
    while (m_cnt != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    chk(q.size() == 0, "R10 reads outstanding", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(pos == '0, "R1 position in reset", int'(pos[5:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 recall of data register 0");
    issue(4'd2, 2'd2, 0, 0);                 // R10 read position
    issue(4'd4, 2'd3, 2'd0, 0);              // R10 read data register
    issue(4'd1, 2'd1, 0, 6'd33); check_state("R2 direct load");
    issue(4'd8, 2'd1, 0, 0);     check_state("R5 increment");
    issue(4'd9, 2'd1, 0, 0);     check_state("R5 decrement");
    issue(4'd1, 2'd3, 0, 6'd63); issue(4'd8, 2'd3, 0, 0); check_state("R5 hold at 63");
    issue(4'd1, 2'd0, 0, 6'd0);  issue(4'd9, 2'd0, 0, 0); check_state("R5 hold at 0");
    issue(4'd3, 2'd2, 2'd3, 6'd45);
    check_state("R7 data write starts busy");
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == NV, "R7 busy length", n, NV);
    issue(4'd3, 2'd2, 2'd1, 6'd5);
    issue(4'd3, 2'd2, 2'd1, 6'd7);           // R9: arrives while busy
    issue(4'd4, 2'd2, 2'd1, 0);
    wait_idle();
    issue(4'd5, 2'd2, 2'd3, 0);  check_state("R3 copy data register to position");
    issue(4'd6, 2'd1, 2'd2, 0);  check_state("R7 copy position to data register");
    wait_idle();
    issue(4'd4, 2'd1, 2'd2, 0);              // expect 33
    wp = 1'b0;
    issue(4'd3, 2'd0, 2'd1, 6'd9); check_state("R8 write protect blocks");
    issue(4'd6, 2'd0, 2'd2, 0);    check_state("R8 write protect blocks copy");
    issue(4'd1, 2'd0, 0, 6'd17);   check_state("R8 position load under protect");
    issue(4'd4, 2'd0, 2'd1, 0);
    issue(4'd4, 2'd0, 2'd2, 0);
    wp = 1'b1;
    for (int c = 0; c < 4; c++) begin
      issue(4'd3, 2'(c), 2'd1, 6'(50 + c));
      wait_idle();
    end
    issue(4'd7, 2'd0, 2'd1, 0);  check_state("R4 global copy");
    issue(4'd15, 2'd1, 2'd1, 6'd1); check_state("R11 undefined opcode");
    issue(4'd0, 2'd1, 2'd1, 6'd1);  check_state("R11 no-op");
    repeat (3) @(negedge clk);
    check_state("R11 idle");
    finish_run();
  end
endmodule